// File: doc/BRIEF.md
# DC offset estimator and corrector

The block follows the slowly moving mean of a signed sample stream with a first-order leaky integrator and can remove that mean from two outputs. Each valid sample moves an internal accumulator toward the sample by a power-of-two fraction of the gap. The fraction is set by a small shift field, so the tracking bandwidth can be chosen over many octaves without a multiplier. A freeze input stops the integrator and keeps the last estimate.

Two copies of the input leave the block one cycle after each valid sample. The first is the main data output. The second feeds a downstream monitor. Each has its own enable that chooses between the raw sample and the sample minus the estimate. The subtraction saturates. The current estimate is always visible as a low byte and a six-bit high field.

Top module: `dco_corrector`

## Requirements
- R1: After reset the accumulator is zero, so both estimate fields read 0, and `out_valid`, `out_data` and `mon_data` are 0.
- R2: With F = SHIFT_BASE + K_MAX fractional bits, each valid sample x that arrives while not frozen updates the accumulator as acc += ((x·2^F − acc) >>> (k + SHIFT_BASE)). The >>> is arithmetic. The estimate is floor(acc / 2^F).
- R3: A shift value k above K_MAX behaves exactly like K_MAX. With the default parameters, 14 and 15 act as 13.
- R4: While `cfg_freeze` is high the estimate holds its value, and samples still flow to both outputs.
- R5: A cycle without `in_valid` changes neither the estimate nor the data outputs, whatever `in_data` carries.
- R6: One cycle after a valid sample x, `out_data` equals x − e when `cfg_path_en` is high and x otherwise. Here e is the estimate held before that sample's update.
- R7: `mon_data` follows the rule of R6 under `cfg_mon_en`, independently of `cfg_path_en`.
- R8: A corrected value outside the signed DW-bit range clamps to −2^(DW−1) or 2^(DW−1)−1 instead of wrapping.
- R9: `out_valid` is high exactly in the cycle after a valid input.
- R10: `est_lo` carries bits 7:0 and `est_hi` carries bits 13:8 of the two's-complement estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 14 | Signed input sample |
| cfg_freeze | input | 1 | Hold the estimate |
| cfg_shift | input | 4 | Bandwidth shift k, clamped to K_MAX |
| cfg_path_en | input | 1 | Subtract estimate on the main output |
| cfg_mon_en | input | 1 | Subtract estimate on the monitor output |
| out_valid | output | 1 | Output strobe |
| out_data | output | 14 | Main output sample |
| mon_data | output | 14 | Monitor output sample |
| est_lo | output | 8 | Estimate bits 7:0 |
| est_hi | output | 6 | Estimate bits 13:8 |

## Verification
The bench builds the block with SHIFT_BASE = 2 and keeps K_MAX = 13 and the 14-bit width. At k = 0 the integrator then closes a quarter of the gap per sample. This lets a few dozen samples drive the estimate close to full scale, which is what both saturation corners need. The smallest weight, 2^-15, still exercises the clamp of shifts 14 and 15 with exact results. A bit-exact model of the integrator compares the estimate and both outputs after every sample.

// File: rtl/dco_accum.sv
module dco_accum #(
  parameter int DW         = 14,
  parameter int KW         = 4,
  parameter int SHIFT_BASE = 14,
  parameter int K_MAX      = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_en,
  input  logic signed [DW-1:0] x,
  input  logic [KW-1:0]        k,
  output logic signed [DW-1:0] est
);
  localparam int FRAC = SHIFT_BASE + K_MAX;
  localparam int AW   = DW + FRAC;
  localparam int SW   = $clog2(FRAC + 1);

  function automatic logic [KW-1:0] clamp_k(input logic [KW-1:0] kin);
    return (kin > KW'(K_MAX)) ? KW'(K_MAX) : kin;
  endfunction

  logic signed [AW-1:0] acc_q, acc_nxt, x_ext;
  logic signed [AW:0]   diff, step;
  logic [KW-1:0]        k_eff;
  logic [SW-1:0]        shamt;

  always_comb begin
    k_eff   = clamp_k(k);
    shamt   = SW'(k_eff) + SW'(SHIFT_BASE);
    x_ext   = {x, {FRAC{1'b0}}};
    diff    = $signed({x_ext[AW-1], x_ext}) - $signed({acc_q[AW-1], acc_q});
    step    = diff >>> shamt;
    acc_nxt = acc_q + step[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (upd_en) acc_q <= acc_nxt;
  end

  assign est = acc_q[AW-1:FRAC];

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(acc_q));
  p_toward_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && (x_ext >= acc_q) |=> (acc_q >= $past(acc_q)) && (acc_q <= $past(x_ext)));
  p_toward_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && (x_ext < acc_q) |=> (acc_q <= $past(acc_q)) && (acc_q >= $past(x_ext)));
endmodule

// File: rtl/dco_apply.sv
module dco_apply #(
  parameter int DW = 14
) (
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] est,
  output logic signed [DW-1:0] y
);
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  function automatic logic signed [DW-1:0] sat_sub(input logic signed [DW-1:0] a,
                                                  input logic signed [DW-1:0] b);
    logic signed [DW:0] d;
    d = $signed({a[DW-1], a}) - $signed({b[DW-1], b});
    if (d[DW] != d[DW-1]) return d[DW] ? MINV : MAXV;
    return d[DW-1:0];
  endfunction

  assign y = en ? sat_sub(x, est) : x;
endmodule

// File: rtl/dco_corrector.sv
module dco_corrector #(
  parameter int DW         = 14,
  parameter int KW         = 4,
  parameter int SHIFT_BASE = 14,
  parameter int K_MAX      = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          cfg_freeze,
  input  logic [KW-1:0] cfg_shift,
  input  logic          cfg_path_en,
  input  logic          cfg_mon_en,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [DW-1:0] mon_data,
  output logic [7:0]    est_lo,
  output logic [DW-9:0] est_hi
);
  logic signed [DW-1:0] est, path_y, mon_y;
  logic                 upd_en;

  assign upd_en = in_valid && !cfg_freeze;

  dco_accum #(.DW(DW), .KW(KW), .SHIFT_BASE(SHIFT_BASE), .K_MAX(K_MAX)) u_accum (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .x(in_data), .k(cfg_shift), .est(est));

  dco_apply #(.DW(DW)) u_path (.en(cfg_path_en), .x(in_data), .est(est), .y(path_y));
  dco_apply #(.DW(DW)) u_mon  (.en(cfg_mon_en),  .x(in_data), .est(est), .y(mon_y));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      mon_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= path_y;
        mon_data <= mon_y;
      end
    end
  end

  assign est_lo = est[7:0];
  assign est_hi = est[DW-1:8];

  p_out_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  p_freeze_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_freeze |=> $stable({est_hi, est_lo}));
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !cfg_path_en |=> out_data == $past(in_data));
  p_mon_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !cfg_mon_en |=> mon_data == $past(in_data));
  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data) && $stable(mon_data));
endmodule

// File: tb/dco_corrector_tb.sv
`timescale 1ns/1ps
module dco_corrector_tb;
  localparam int FRAC = 15;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [13:0] in_data = '0;
  logic cfg_freeze = 0, cfg_path_en = 0, cfg_mon_en = 0;
  logic [3:0] cfg_shift = 0;
  logic out_valid;
  logic [13:0] out_data, mon_data;
  logic [7:0] est_lo;
  logic [5:0] est_hi;
  int n_chk = 0, n_fail = 0;
  longint m_acc = 0;

  always #2.5 clk = ~clk;

  dco_corrector #(.DW(14), .KW(4), .SHIFT_BASE(2), .K_MAX(13)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_freeze(cfg_freeze), .cfg_shift(cfg_shift), .cfg_path_en(cfg_path_en),
    .cfg_mon_en(cfg_mon_en), .out_valid(out_valid), .out_data(out_data),
    .mon_data(mon_data), .est_lo(est_lo), .est_hi(est_hi));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_est();
    return int'(m_acc >>> FRAC);
  endfunction

  function automatic int clip(input int v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  function automatic int dut_est();
    logic [13:0] e;
    e = {est_hi, est_lo};
    return int'($signed(e));
  endfunction

  task automatic check_est(input string req);
    int e;
    logic [13:0] eb;
    e = m_est();
    eb = 14'(e);
    chk(dut_est() == e, req, dut_est(), e);
    chk(est_lo == eb[7:0] && est_hi == eb[13:8], "R10", {est_hi, est_lo}, int'(eb));
  endtask

  task automatic send(input int x);
    int e0, ep, em, kk, raw;
    e0 = m_est();
    raw = x - e0;
    ep = cfg_path_en ? clip(raw) : x;
    em = cfg_mon_en ? clip(raw) : x;
    @(negedge clk);
    in_valid = 1; in_data = 14'(x);
    if (!cfg_freeze) begin
      kk = (int'(cfg_shift) > 13) ? 13 : int'(cfg_shift);
      m_acc = m_acc + (((longint'(x) <<< FRAC) - m_acc) >>> (kk + 2));
    end
    @(negedge clk);
    in_valid = 0; in_data = 14'h1555;
    chk(out_valid == 1'b1, "R9", out_valid, 1);
    chk(int'($signed(out_data)) == ep, (cfg_path_en && ep != raw) ? "R8" : "R6",
        int'($signed(out_data)), ep);
    chk(int'($signed(mon_data)) == em, (cfg_mon_en && em != raw) ? "R8" : "R7",
        int'($signed(mon_data)), em);
    check_est(cfg_freeze ? "R4" : (cfg_shift > 4'd13 ? "R3" : "R2"));
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", out_valid, 0);
  endtask

  task automatic t_reset();
    chk(out_valid == 0, "R1", out_valid, 0);
    chk(out_data == 0 && mon_data == 0, "R1", out_data, 0);
    chk(dut_est() == 0, "R1", dut_est(), 0);
  endtask

  task automatic t_track();
    cfg_shift = 0; cfg_path_en = 1; cfg_mon_en = 0;
    for (int i = 0; i < 12; i++) send(1000);
    cfg_shift = 3;
    for (int i = 0; i < 8; i++) send(-2500 + 37 * i);
  endtask

  task automatic t_clamp();
    cfg_shift = 15; cfg_mon_en = 1;
    for (int i = 0; i < 6; i++) send(7000);
    cfg_shift = 14;
    for (int i = 0; i < 6; i++) send(-7000);
  endtask

  task automatic t_freeze();
    int held;
    cfg_shift = 0; cfg_freeze = 1;
    held = dut_est();
    for (int i = 0; i < 5; i++) send(4000 - 900 * i);
    chk(dut_est() == held, "R4", dut_est(), held);
    cfg_freeze = 0;
  endtask

  task automatic t_idle();
    int e;
    logic [13:0] od, md;
    e = dut_est(); od = out_data; md = mon_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); in_data = 14'(i * 3001);
    end
    @(negedge clk);
    chk(dut_est() == e, "R5", dut_est(), e);
    chk(out_data == od && mon_data == md, "R5", out_data, od);
  endtask

  task automatic t_enables();
    cfg_path_en = 0; cfg_mon_en = 1; send(123);
    cfg_path_en = 1; cfg_mon_en = 0; send(-456);
    cfg_path_en = 0; cfg_mon_en = 0; send(789);
    cfg_path_en = 1; cfg_mon_en = 1; send(-10);
  endtask

  task automatic t_sat();
    cfg_shift = 0; cfg_path_en = 1; cfg_mon_en = 1;
    for (int i = 0; i < 40; i++) send(8191);
    send(-8192);
    for (int i = 0; i < 40; i++) send(-8192);
    send(8191);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_track();
    t_clamp();
    t_freeze();
    t_idle();
    t_enables();
    t_sat();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule